// File: doc/BRIEF.md
# Chainable Synchronous Preset Counter

This block is a synchronous binary up-counter assembled from identical 4-bit stages. A parameter sets how many stages are chained. Every stage shares the clock, an active-low clear, an active-low parallel load and a common count enable. A second count enable gates the carry and goes to the lowest stage only. Each higher stage takes its carry enable from the terminal-count output of the stage below it. The counter therefore behaves as one wide binary counter, and the terminal-count output of the top stage can feed a further counter.

Every state change happens on the rising clock edge, the clear included. The mode is chosen by fixed priority: clear first, then load, then count, then hold. The terminal-count output is combinational. It depends only on the carry enable and the stored count, and the common count enable has no effect on it, so chained stages look ahead in parallel. The power-up state is undefined, and the count is meaningful only after one clear cycle.

Top module: `sync_preset_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, `q` becomes all zeros, whatever `load_n`, the enables and `din` are.
- R2: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din`, whatever the enables are.
- R3: When `clr_n` and `load_n` are both high and both `cnt_en` and `carry_en` are high at a rising edge, `q` increases by one.
- R4: When `clr_n` and `load_n` are both high and either `cnt_en` or `carry_en` is low at a rising edge, `q` keeps its value.
- R5: `carry_out` is high exactly when `carry_en` is high and every bit of `q` is 1. `cnt_en` has no effect on it.
- R6: A count step from the all-ones value gives all zeros.
- R7: A stage above the lowest one advances only in a cycle when every stage below it holds all ones. The full-width value therefore steps as one binary number across stage boundaries, for example 0x0F to 0x10.
- R8: Bit 0 of `din` and `q` is the least significant bit, and bit index i of `din` loads bit index i of `q`.
- R9: `carry_out` follows `carry_en` in the same cycle with no clock edge in between. A low `carry_en` forces it low even when the count is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Common count enable, shared by all stages |
| carry_en | input | 1 | Count enable for the lowest stage; also gates the carry |
| din | input | STAGE_W*NSTAGES | Parallel load data, bit 0 least significant |
| q | output | STAGE_W*NSTAGES | Counter value |
| carry_out | output | 1 | Terminal-count output of the top stage |

## Verification
A wrong stored value appears on `q` one edge after the mode decision that produced it. A fault in the carry ripple between stages stays invisible until the lower stage reaches all ones. It then shows as an upper nibble that advances too early or fails to advance at the boundary. A gating error in `carry_out` shows in the same cycle as the input change, at the all-ones state only. For that reason the bench loads every 8-bit starting value and applies every one of the sixteen combinations of control inputs at each.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [1:0] {
    MD_CLEAR = 2'd0,
    MD_LOAD  = 2'd1,
    MD_COUNT = 2'd2,
    MD_HOLD  = 2'd3
  } spc_mode_e;

  // Fixed priority: clear, load, count, hold.
  function automatic spc_mode_e pick_mode(input logic clr_n, input logic load_n,
                                          input logic cen, input logic cin_en);
    if (!clr_n)            return MD_CLEAR;
    else if (!load_n)      return MD_LOAD;
    else if (cen && cin_en) return MD_COUNT;
    else                   return MD_HOLD;
  endfunction

endpackage

// File: rtl/spc_mode_dec.sv
module spc_mode_dec
  import spc_pkg::*;
(
  input  logic      clr_n,
  input  logic      load_n,
  input  logic      cen,
  input  logic      cin_en,
  output spc_mode_e mode
);

  always_comb mode = pick_mode(clr_n, load_n, cen, cin_en);

endmodule

// File: rtl/spc_stage.sv
module spc_stage
  import spc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         cen,
  input  logic         cin_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);

  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] step_value(input spc_mode_e m,
                                              input logic [W-1:0] cur,
                                              input logic [W-1:0] d);
    case (m)
      MD_CLEAR: return '0;
      MD_LOAD:  return d;
      MD_COUNT: return cur + ONE;
      default:  return cur;
    endcase
  endfunction

  spc_mode_e    mode;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         at_top;

  spc_mode_dec u_dec (
    .clr_n (clr_n),
    .load_n(load_n),
    .cen   (cen),
    .cin_en(cin_en),
    .mode  (mode)
  );

  always_comb q_nxt = step_value(mode, q_r, din);

  always_ff @(posedge clk) q_r <= q_nxt;

  assign at_top = &q_r;
  assign carry  = cin_en & at_top;
  assign q      = q_r;

  // Assertion qualifier: armed once a clear has been seen.
  logic clr_seen;
  always_ff @(posedge clk) if (!clr_n) clr_seen <= 1'b1;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!clr_seen)
    !clr_n |=> (q == '0)); // R1
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!clr_seen)
    (clr_n && !load_n) |=> (q == $past(din))); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_seen)
    (clr_n && load_n && cen && cin_en) |=> (q == $past(q) + ONE)); // R3
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!clr_seen)
    (clr_n && load_n && !(cen && cin_en)) |=> $stable(q)); // R4

endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter #(
  parameter int STAGE_W = 4,
  parameter int NSTAGES = 2
) (
  input  logic                       clk,
  input  logic                       clr_n,
  input  logic                       load_n,
  input  logic                       cnt_en,
  input  logic                       carry_en,
  input  logic [STAGE_W*NSTAGES-1:0] din,
  output logic [STAGE_W*NSTAGES-1:0] q,
  output logic                       carry_out
);

  localparam int W = STAGE_W * NSTAGES;

  logic [NSTAGES:0] rip;
  assign rip[0] = carry_en;

  for (genvar i = 0; i < NSTAGES; i++) begin : g_stage
    spc_stage #(.W(STAGE_W)) u_stage (
      .clk   (clk),
      .clr_n (clr_n),
      .load_n(load_n),
      .cen   (cnt_en),
      .cin_en(rip[i]),
      .din   (din[i*STAGE_W +: STAGE_W]),
      .q     (q[i*STAGE_W +: STAGE_W]),
      .carry (rip[i+1])
    );
  end

  assign carry_out = rip[NSTAGES];

  logic clr_seen;
  always_ff @(posedge clk) if (!clr_n) clr_seen <= 1'b1;

  AST_CARRY_FULL: assert property (@(posedge clk) disable iff (!clr_seen)
    carry_out |-> (&q && carry_en)); // R5
  AST_CARRY_GATE: assert property (@(posedge clk) disable iff (!clr_seen)
    !carry_en |-> !carry_out); // R9
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clr_seen)
    (clr_n && load_n && cnt_en && carry_en && (&q)) |=> (q == '0)); // R6

  for (genvar k = 1; k < NSTAGES; k++) begin : g_chain_chk
    AST_UPPER_WAITS: assert property (@(posedge clk) disable iff (!clr_seen)
      (clr_n && load_n && !(&q[k*STAGE_W-1:0] && carry_en))
        |=> $stable(q[k*STAGE_W +: STAGE_W])); // R7
  end

endmodule

// File: tb/sync_preset_counter_bench.sv
`timescale 1ns/1ps
module sync_preset_counter_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         load_n = 1'b1;
  logic         cnt_en = 1'b0;
  logic         carry_en = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic         carry_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sync_preset_counter #(.STAGE_W(4), .NSTAGES(2)) u_sync_preset_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .carry_en(carry_en), .din(din), .q(q), .carry_out(carry_out)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(1_500_000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] model;
    logic [W-1:0] exp;
    string        tag;
    // Reset state via clear (R1)
    @(negedge clk); @(negedge clk);
    check("R1 clear from power-up", q, 8'h00);
    model = '0;

    // Bit order (R8): load a single set bit
    clr_n = 1'b1; load_n = 1'b0; din = 8'h01;
    @(negedge clk);
    check("R8 din[0] lands in q[0]", {7'd0, q[0]}, 8'h01);
    check("R8 upper bits zero", {1'b0, q[7:1]}, 8'h00);

    for (int s = 0; s < 256; s++) begin
      for (int c = 0; c < 16; c++) begin
        // preset the start value
        clr_n = 1'b1; load_n = 1'b0; cnt_en = 1'b0; carry_en = 1'b0; din = s[W-1:0];
        @(negedge clk);
        model = s[W-1:0];
        // apply one control combination
        clr_n = c[3]; load_n = c[2]; cnt_en = c[1]; carry_en = c[0];
        din = W'((s * 7 + 13 + c * 29) % 256);
        #1;
        tag = carry_en ? "R5 carry at terminal count" : "R9 carry gated by carry_en";
        check(tag, {7'd0, carry_out}, {7'd0, (carry_en && model == 8'hFF)});
        if (!clr_n) begin
          exp = '0; tag = "R1 clear overrides all";
        end else if (!load_n) begin
          exp = din; tag = "R2 load overrides count";
        end else if (cnt_en && carry_en) begin
          exp = model + 8'd1;
          if (model == 8'hFF)        tag = "R6 wrap to zero";
          else if (model[3:0] == 4'hF) tag = "R7 carry into upper stage";
          else                        tag = "R3 count step";
        end else begin
          exp = model; tag = "R4 hold with an enable low";
        end
        @(negedge clk);
        check(tag, q, exp);
      end
    end
    finish_run();
  end

endmodule